// File: doc/BRIEF.md
# Atomic Memory Synchronization Unit

This block sits on the memory side of a small multiprocessor and owns a shared word memory that several processor ports use for locks, counters and other synchronization variables. Each port presents one operation at a time over a valid/ready handshake. The operation is one of: plain load, plain store, atomic exchange, fetch-and-increment, load-linked or store-conditional. A round-robin arbiter accepts at most one operation per clock. Each accepted operation reads the word, computes the result and writes the word back in that same cycle, so no other access can fall between its read and its write.

A reservation monitor keeps one linked address per port. Load-linked sets the issuing port's reservation. A store-conditional succeeds only while that reservation is still valid for the same address. Any write that lands on a word clears every reservation held on that word. This lets software build lock-free read-modify-write sequences next to the simpler exchange-based spin locks, where 0 marks a free lock and 1 marks a held one.

The result of an accepted operation comes back to the issuing port as a one-cycle response pulse on the clock after acceptance.

Top module: `atomic_sync_unit`

## Requirements
- R1: After reset, no response is valid, every memory word reads 0 and no port holds a reservation. A store-conditional issued before any load-linked therefore fails.
- R2: The opcode field is 3 bits: 0 load, 1 store, 2 exchange, 3 fetch-and-increment, 4 load-linked, 5 store-conditional; 6 and 7 act as load. A load returns the addressed word. A store writes the request data and returns 0. The response appears on the issuing port on the clock after acceptance.
- R3: An exchange writes the request data into the word and returns the word's previous value.
- R4: Fetch-and-increment returns the word's previous value and stores that value plus one, wrapping to 0 from the all-ones value.
- R5: Load-linked returns the addressed word and records a reservation for that address on the issuing port. A later load-linked from the same port replaces the earlier reservation.
- R6: A store-conditional writes its data and returns 1 only when the issuing port holds a valid reservation on that same address. Otherwise it leaves memory unchanged and returns 0. In both cases it clears the issuing port's reservation.
- R7: Every write (store, exchange, fetch-and-increment or successful store-conditional) clears the reservation of every port whose linked address equals the written address. Reservations on other addresses are kept.
- R8: At most one port sees ready in a cycle, and only a port whose valid is high. Among the requesting ports, the grant goes to the first one found at or after a rotating pointer. After each grant the pointer moves to the port just after the granted one.
- R9: Used as a lock, an exchange of 1 that returns 0 acquires it, an exchange of 1 that returns 1 finds it held, and a plain store of 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Per-port request valid |
| req_ready | output | NPORTS | Per-port accept, at most one bit set |
| req_op | input | NPORTS*3 | Per-port opcode, port p at bits [3p+2:3p] |
| req_addr | input | NPORTS*AW | Per-port word address |
| req_wdata | input | NPORTS*DW | Per-port store / exchange / conditional data |
| rsp_valid | output | NPORTS | Per-port one-cycle response strobe |
| rsp_data | output | NPORTS*DW | Per-port response value |

## Verification
The interesting collision is a store-conditional from one port and a plain store, exchange or increment from another port aimed at the same linked word in the same cycle. Only the arbiter decides which of the two lands first, and that choice alone decides whether the conditional succeeds. The bench provokes this through a long stretch of random traffic confined to four addresses, with every port active. It also runs directed rounds where all ports request together. A behavioural reference model applies the same round-robin order and judges every grant and every response on every clock.

// File: rtl/sync_pkg.sv
package sync_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_FINC  = 3'd3,
        OP_LL    = 3'd4,
        OP_SC    = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } sync_op_e;

    localparam int OP_W = 3;

endpackage

// File: rtl/sync_rr_arbiter.sv
module sync_rr_arbiter #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        int cand;
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            cand = int'(st_q.ptr) + k;
            if (cand >= N) cand = cand - N;
            if (!gnt_any && req[cand]) begin
                gnt_any    = 1'b1;
                gnt[cand]  = 1'b1;
                gnt_idx    = IW'(cand);
            end
        end
        if (gnt_any) begin
            if (int'(gnt_idx) == N - 1) st_d.ptr = '0;
            else                        st_d.ptr = gnt_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    p_idle_grants_nothing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (gnt == '0));

endmodule

// File: rtl/sync_resv_monitor.sv
module sync_resv_monitor
    import sync_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_fire,
    input  logic [IW-1:0] op_port,
    input  sync_op_e      op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic          wr_en,
    output logic          sc_ok
);

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] adr;
    } resv_st_t;

    resv_st_t st_d, st_q;

    always_comb begin
        sc_ok = st_q.vld[op_port] && (st_q.adr[op_port] == op_addr);
    end

    always_comb begin
        st_d = st_q;
        if (op_fire) begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && st_q.vld[i] && (st_q.adr[i] == op_addr))
                    st_d.vld[i] = 1'b0;
            end
            if (op_kind == OP_LL) begin
                st_d.vld[op_port] = 1'b1;
                st_d.adr[op_port] = op_addr;
            end
            if (op_kind == OP_SC)
                st_d.vld[op_port] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_ll_sets_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && op_kind == OP_LL)
        |=> (st_q.vld[$past(op_port)] && st_q.adr[$past(op_port)] == $past(op_addr)));

    p_sc_drops_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && op_kind == OP_SC) |=> !st_q.vld[$past(op_port)]);

    for (genvar gi = 0; gi < N; gi++) begin : g_clear_chk
        p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (op_fire && wr_en)
            |=> !(st_q.vld[gi] && st_q.adr[gi] == $past(op_addr)));
    end

endmodule

// File: rtl/sync_op_unit.sv
module sync_op_unit
    import sync_pkg::*;
#(
    parameter int DW = 16
) (
    input  sync_op_e      op_kind,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] wdata,
    input  logic          sc_ok,
    output logic          wr_en,
    output logic [DW-1:0] new_word,
    output logic [DW-1:0] rsp_word
);

    always_comb begin
        wr_en    = 1'b0;
        new_word = wdata;
        rsp_word = old_word;
        unique case (op_kind)
            OP_STORE: begin
                wr_en    = 1'b1;
                rsp_word = '0;
            end
            OP_SWAP: begin
                wr_en    = 1'b1;
            end
            OP_FINC: begin
                wr_en    = 1'b1;
                new_word = old_word + 1'b1;
            end
            OP_SC: begin
                wr_en    = sc_ok;
                rsp_word = DW'(sc_ok);
            end
            default: begin
                wr_en    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/atomic_sync_unit.sv
module atomic_sync_unit
    import sync_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = 4,
    parameter int DW     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORTS-1:0]     req_valid,
    output logic [NPORTS-1:0]     req_ready,
    input  logic [NPORTS*3-1:0]   req_op,
    input  logic [NPORTS*AW-1:0]  req_addr,
    input  logic [NPORTS*DW-1:0]  req_wdata,
    output logic [NPORTS-1:0]     rsp_valid,
    output logic [NPORTS*DW-1:0]  rsp_data
);

    localparam int IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0]  mem;
        logic [NPORTS-1:0]         rvld;
        logic [NPORTS-1:0][DW-1:0] rdat;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NPORTS-1:0] gnt;
    logic [IW-1:0]     gnt_idx;
    logic              gnt_any;
    sync_op_e          g_op;
    logic [AW-1:0]     g_addr;
    logic [DW-1:0]     g_wdata;
    logic [DW-1:0]     cur_word;
    logic              sc_ok;
    logic              wr_en;
    logic [DW-1:0]     new_word;
    logic [DW-1:0]     rsp_word;

    sync_rr_arbiter #(.N(NPORTS), .IW(IW)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    always_comb begin
        g_op     = sync_op_e'(req_op[gnt_idx*3 +: 3]);
        g_addr   = req_addr[gnt_idx*AW +: AW];
        g_wdata  = req_wdata[gnt_idx*DW +: DW];
        cur_word = st_q.mem[g_addr];
    end

    sync_resv_monitor #(.N(NPORTS), .AW(AW), .IW(IW)) i_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_fire (gnt_any),
        .op_port (gnt_idx),
        .op_kind (g_op),
        .op_addr (g_addr),
        .wr_en   (wr_en),
        .sc_ok   (sc_ok)
    );

    sync_op_unit #(.DW(DW)) i_op (
        .op_kind  (g_op),
        .old_word (cur_word),
        .wdata    (g_wdata),
        .sc_ok    (sc_ok),
        .wr_en    (wr_en),
        .new_word (new_word),
        .rsp_word (rsp_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rvld = gnt;
        if (gnt_any) begin
            st_d.rdat[gnt_idx] = rsp_word;
            if (wr_en) st_d.mem[g_addr] = new_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = gnt;
    assign rsp_valid = st_q.rvld;
    assign rsp_data  = st_q.rdat;

    p_swap_returns_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && g_op == OP_SWAP)
        |=> (st_q.rdat[$past(gnt_idx)] == $past(cur_word)
             && st_q.mem[$past(g_addr)] == $past(g_wdata)));

    p_finc_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && g_op == OP_FINC)
        |=> (st_q.mem[$past(g_addr)] == DW'($past(cur_word) + 1'b1)));

    p_sc_fail_keeps_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && g_op == OP_SC && !sc_ok)
        |=> (st_q.mem[$past(g_addr)] == $past(cur_word) && st_q.rdat[$past(gnt_idx)] == '0));

    p_single_response_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rsp_valid) <= 1);

endmodule

// File: tb/test_atomic_sync_unit.sv
module test_atomic_sync_unit;

    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid;
    logic [N-1:0]      req_ready;
    logic [N*3-1:0]    req_op;
    logic [N*AW-1:0]   req_addr;
    logic [N*DW-1:0]   req_wdata;
    logic [N-1:0]      rsp_valid;
    logic [N*DW-1:0]   rsp_data;

    always #10 clk = ~clk;

    atomic_sync_unit #(.NPORTS(N), .AW(AW), .DW(DW)) i_atomic_sync_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string scen = "R1";

    int m_mem [DEPTH];
    bit m_rv  [N];
    int m_ra  [N];
    int m_ptr = 0;

    bit pv [N];
    int pop[N];
    int pa [N];
    int pd [N];

    bit    e_vld[N];
    int    e_dat[N];
    string e_tag[N];

    function automatic string op_tag(int op);
        case (op)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s/%s %s: actual %0h expected %0h", tag, scen, what, act, exp);
        end
    endtask

    task automatic clear_reqs();
        for (int i = 0; i < N; i++) begin
            pv[i] = 0; pop[i] = 0; pa[i] = 0; pd[i] = 0;
        end
    endtask

    task automatic put(int p, int op, int a, int d);
        pv[p] = 1; pop[p] = op; pa[p] = a; pd[p] = d;
    endtask

    task automatic run_cycle();
        int g;
        int old;
        int cand;
        bit wr;
        int nv;
        int rv;
        logic [N-1:0] exp_rdy;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            chk(e_vld[i] ? e_tag[i] : "R2", int'(rsp_valid[i]), int'(e_vld[i]),
                $sformatf("rsp_valid port %0d", i));
            if (e_vld[i])
                chk(e_tag[i], int'(rsp_data[i*DW +: DW]), e_dat[i],
                    $sformatf("rsp_data port %0d", i));
        end
        for (int i = 0; i < N; i++) begin
            req_valid[i]           = pv[i];
            req_op[i*3 +: 3]       = 3'(pop[i]);
            req_addr[i*AW +: AW]   = AW'(pa[i]);
            req_wdata[i*DW +: DW]  = DW'(pd[i]);
        end
        #1;
        g = -1;
        for (int k = 0; k < N; k++) begin
            cand = (m_ptr + k) % N;
            if (g < 0 && pv[cand]) g = cand;
        end
        exp_rdy = '0;
        if (g >= 0) exp_rdy[g] = 1'b1;
        chk("R8", int'(req_ready), int'(exp_rdy), "req_ready");
        for (int i = 0; i < N; i++) e_vld[i] = 0;
        if (g >= 0) begin
            m_ptr = (g + 1) % N;
            old = m_mem[pa[g]];
            wr = 0; nv = pd[g] & 16'hFFFF; rv = old;
            case (pop[g])
                1: begin wr = 1; rv = 0; end
                2: wr = 1;
                3: begin wr = 1; nv = (old + 1) & 16'hFFFF; end
                5: begin
                    wr = m_rv[g] && (m_ra[g] == pa[g]);
                    rv = wr ? 1 : 0;
                end
                default: ;
            endcase
            if (wr) begin
                for (int i = 0; i < N; i++)
                    if (m_rv[i] && m_ra[i] == pa[g]) m_rv[i] = 0;
                m_mem[pa[g]] = nv;
            end
            if (pop[g] == 4) begin m_rv[g] = 1; m_ra[g] = pa[g]; end
            if (pop[g] == 5) m_rv[g] = 0;
            e_vld[g] = 1; e_dat[g] = rv; e_tag[g] = op_tag(pop[g]);
        end
    endtask

    task automatic one(int p, int op, int a, int d);
        clear_reqs();
        put(p, op, a, d);
        run_cycle();
    endtask

    task automatic flush();
        clear_reqs();
        run_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        for (int i = 0; i < N; i++) begin m_rv[i] = 0; m_ra[i] = 0; e_vld[i] = 0; end
        clear_reqs();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(rsp_valid), 0, "rsp_valid after reset");
        chk("R1", int'(req_ready), 0, "req_ready idle after reset");

        scen = "R1 reset state";
        one(0, 5, 0, 16'h00AA);
        one(3, 0, 0, 0);
        one(1, 0, 15, 0);

        scen = "R2 load store";
        one(1, 1, 2, 16'h1234);
        one(2, 0, 2, 0);
        one(0, 6, 2, 0);
        one(3, 7, 2, 0);

        scen = "R9 lock";
        one(0, 2, 5, 1);
        one(1, 2, 5, 1);
        one(0, 1, 5, 0);
        one(1, 2, 5, 1);
        one(2, 0, 5, 0);

        scen = "R4 wrap";
        one(2, 1, 3, 16'hFFFF);
        one(2, 3, 3, 0);
        one(1, 0, 3, 0);
        one(3, 3, 3, 0);

        scen = "R6 sc";
        one(2, 4, 7, 0);
        one(2, 5, 7, 16'h0055);
        one(0, 0, 7, 0);
        one(2, 5, 7, 16'h0066);
        one(1, 0, 7, 0);

        scen = "R7 clear";
        one(0, 4, 8, 0);
        one(1, 4, 8, 0);
        one(3, 1, 8, 16'h0009);
        one(0, 5, 8, 16'h0011);
        one(1, 5, 8, 16'h0022);
        one(2, 0, 8, 0);
        one(0, 4, 9, 0);
        one(1, 1, 10, 16'h0033);
        one(0, 5, 9, 16'h0044);
        one(0, 4, 6, 0);
        one(1, 3, 6, 0);
        one(0, 5, 6, 16'h0077);

        scen = "R5 replace";
        one(0, 4, 11, 0);
        one(0, 4, 12, 0);
        one(0, 5, 12, 16'h0C0C);
        one(0, 4, 11, 0);
        one(0, 4, 12, 0);
        one(0, 5, 11, 16'h0B0B);
        one(3, 0, 11, 0);

        scen = "R8 contention";
        for (int r = 0; r < 6; r++) begin
            clear_reqs();
            for (int p = 0; p < N; p++) put(p, (p + r) % 6, 4, 16'h0100 + p);
            run_cycle();
        end
        for (int r = 0; r < 4; r++) begin
            clear_reqs();
            put(1, 3, 13, 0);
            put(3, 3, 13, 0);
            run_cycle();
        end

        scen = "R7 random";
        for (int c = 0; c < 3000; c++) begin
            clear_reqs();
            for (int p = 0; p < N; p++)
                if ($urandom_range(0, 3) != 0)
                    put(p, $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 65535));
            run_cycle();
        end
        flush();
        flush();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule